// File: doc/BRIEF.md
# Prioritized Interrupt Level Recognizer

This block sits between seven active-low interrupt request lines and a processor core. It debounces each line with a two-sample filter taken on the falling clock edge. It applies a 3-bit priority mask and picks the highest recognized level. It hands that level to the core only when the core signals an instruction boundary.

The top level, 7, cannot be masked. It is edge-qualified: a stored event is created by a high-to-low change of the filtered line, and also by every write of the mask while the line is held low. That event is cleared by a level-7 acknowledge.

The presented level is not latched. While the request is pending, the level follows whatever is currently the highest recognized request. A higher request that arrives later therefore replaces a lower one that is still waiting.

The control is a two-state machine, `IDLE` and `PRESENT`, with three named transitions:
- **GRANT** goes from `IDLE` to `PRESENT`. It is taken on a clock where the boundary strobe is high and at least one request is recognized.
- **SERVICED** goes from `PRESENT` to `IDLE`. It is taken on an acknowledge whose level equals the presented level.
- **WITHDRAW** goes from `PRESENT` to `IDLE`. It is taken when no recognized request remains.

In all other cases the machine holds its state.

Top module: `irq_level_recognizer`

## Requirements
- R1: A request line counts as asserted only after it has been sampled low (0 = request) on two consecutive falling clock edges. A line held low across only one falling edge is never recognized.
- R2: A request at level 1 to 6 is recognized only when its level is strictly greater than the mask value `mask` (0 to 7).
- R3: When several requests are recognized together, the presented level is the highest of them.
- R4: `pend` rises only on the rising clock edge at which `boundary` is high and a request is recognized (GRANT). Without a boundary strobe, a recognized request leaves `pend` at 0.
- R5: While `pend` is 1, `pend_level` follows the current highest recognized level, so a newly valid higher request replaces a lower waiting one.
- R6: An acknowledge (`ack_valid` = 1) whose `ack_level` equals `pend_level` clears `pend` on that clock edge (SERVICED). An acknowledge of a different level has no effect.
- R7: Level 7 is recognized at any mask value, including 7. It is recognized only after a high-to-low transition of its filtered line, and a line held low after its level-7 acknowledge is not serviced again.
- R8: A mask write (`mask_wr` = 1) on a clock where the filtered level-7 line is low creates a new level-7 request, even if the mask value written is 7 or is unchanged.
- R9: While reset is asserted, `pend` is 0 and `pend_level` is 0. The level-7 edge detector starts as if its line were high, so a line already low at reset produces one request.
- R10: If no recognized request remains while `pend` is 1, `pend` is 0 at once and the machine returns to `IDLE` on the next edge (WITHDRAW). `pend_level` reads 0 whenever `pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests are sampled on its falling edge, control runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 7 | Request lines, bit k is level k+1, active low |
| mask | input | 3 | Current priority mask value |
| mask_wr | input | 1 | One-cycle strobe marking a write of the mask |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| ack_valid | input | 1 | Acknowledge strobe from the core |
| ack_level | input | 3 | Level being acknowledged |
| pend | output | 1 | A recognized request is presented to the core |
| pend_level | output | 3 | Presented level, 0 when nothing is presented |

## Verification
A line driven just after a rising edge is first sampled on the next falling edge. It becomes valid on the falling edge after that, so the bench waits three full cycles after changing a line before it relies on it.

GRANT, SERVICED, level-7 event updates and mask-write re-triggers all take effect on the rising edge that samples the strobe. The bench therefore checks `pend` and `pend_level` two nanoseconds after that edge.

Preemption and withdrawal act combinationally on the live level. They are checked three cycles after the line change, once the filter has settled.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_LEVELS = 7;
    localparam int LVL_W      = $clog2(NUM_LEVELS + 1);
    localparam int FILT_DEPTH = 2;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } pres_state_t;
endpackage

// File: rtl/irq_sample_filter.sv
module irq_sample_filter #(
    parameter int LINES = 7,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_n,
    output logic [LINES-1:0] valid
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] hist;

        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) hist <= '0;
            else        hist <= {hist[DEPTH-2:0], ~line_n[g]};
        end

        assign valid[g] = &hist;
    end
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic top_valid,
    input  logic mask_wr,
    input  logic top_ack,
    output logic evt
);
    logic prev_low;
    logic fire;

    assign fire = (top_valid && !prev_low) || (top_valid && mask_wr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_low <= 1'b0;
            evt      <= 1'b0;
        end else begin
            prev_low <= top_valid;
            if (fire)         evt <= 1'b1;
            else if (top_ack) evt <= 1'b0;
        end
    end

    // R8: a mask write while the filtered top line is low leaves an event
    a_r8_rearm_on_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (top_valid && mask_wr) |=> evt);
    // R7: an event appears only from a new low or a mask write
    a_r7_event_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> $past(top_valid));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int LEVELS = 7,
    parameter int LW     = 3
) (
    input  logic [LEVELS-1:0] rec,
    output logic              any,
    output logic [LW-1:0]     best
);
    always_comb begin
        best = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (rec[k]) best = LW'(k + 1);
        end
        any = |rec;
    end
endmodule

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer
    import irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] irq_n,
    input  logic [LVL_W-1:0]      mask,
    input  logic                  mask_wr,
    input  logic                  boundary,
    input  logic                  ack_valid,
    input  logic [LVL_W-1:0]      ack_level,
    output logic                  pend,
    output logic [LVL_W-1:0]      pend_level
);
    localparam int TOP = NUM_LEVELS - 1;

    logic [NUM_LEVELS-1:0] valid;
    logic [NUM_LEVELS-1:0] rec;
    logic                  top_evt;
    logic                  top_ack;
    logic                  any_rec;
    logic [LVL_W-1:0]      best;
    logic                  ack_hit;
    pres_state_t           state, state_nx;

    irq_sample_filter #(.LINES(NUM_LEVELS), .DEPTH(FILT_DEPTH)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (irq_n),
        .valid  (valid)
    );

    assign top_ack = pend && ack_valid && (ack_level == LVL_W'(NUM_LEVELS));

    irq_nmi_edge u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .top_valid (valid[TOP]),
        .mask_wr   (mask_wr),
        .top_ack   (top_ack),
        .evt       (top_evt)
    );

    always_comb begin
        rec = '0;
        for (int k = 0; k < TOP; k++) begin
            rec[k] = valid[k] && ((k + 1) > int'(mask));
        end
        rec[TOP] = top_evt;
    end

    irq_prio_pick #(.LEVELS(NUM_LEVELS), .LW(LVL_W)) u_pick (
        .rec  (rec),
        .any  (any_rec),
        .best (best)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state: GRANT, SERVICED, WITHDRAW
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (boundary && any_rec) state_nx = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (ack_hit)       state_nx = ST_IDLE;
                else if (!any_rec) state_nx = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        pend       = 1'b0;
        pend_level = '0;
        unique case (state)
            ST_IDLE: ;
            ST_PRESENT: begin
                pend       = any_rec;
                pend_level = any_rec ? best : '0;
            end
        endcase
    end

    assign ack_hit = pend && ack_valid && (ack_level == pend_level);

    // R4: pend rises only after a boundary strobe
    a_r4_rise_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(boundary));
    // R6: a matching acknowledge removes the presentation
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ack_valid && ack_level == pend_level) |=> (state == ST_IDLE));
    // R2: a maskable presented level is above the mask
    a_r2_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && pend_level != LVL_W'(NUM_LEVELS)) |-> (pend_level > mask));
    // R10: level reads zero exactly when nothing is presented
    a_r10_level_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (pend_level != '0));
endmodule

// File: tb/tb_irq_level_recognizer.sv
module tb_irq_level_recognizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] irq_n = 7'h7F;
    logic [2:0] mask = 3'd0;
    logic       mask_wr = 1'b0;
    logic       boundary = 1'b0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_level = 3'd0;
    logic       pend;
    logic [2:0] pend_level;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    irq_level_recognizer dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .mask(mask), .mask_wr(mask_wr),
        .boundary(boundary), .ack_valid(ack_valid), .ack_level(ack_level),
        .pend(pend), .pend_level(pend_level)
    );

    // {irq_n[6:0], mask, expected pend, expected level}
    localparam logic [13:0] VEC [14] = '{
        {7'b1111110, 3'd0, 1'b1, 3'd1},
        {7'b1111110, 3'd1, 1'b0, 3'd0},
        {7'b1110111, 3'd3, 1'b1, 3'd4},
        {7'b1110111, 3'd4, 1'b0, 3'd0},
        {7'b1011111, 3'd5, 1'b1, 3'd6},
        {7'b1011111, 3'd6, 1'b0, 3'd0},
        {7'b1011011, 3'd2, 1'b1, 3'd6},
        {7'b1101101, 3'd5, 1'b0, 3'd0},
        {7'b1101101, 3'd1, 1'b1, 3'd5},
        {7'b0111111, 3'd7, 1'b1, 3'd7},
        {7'b0111011, 3'd0, 1'b1, 3'd7},
        {7'b1101111, 3'd7, 1'b0, 3'd0},
        {7'b1111101, 3'd0, 1'b1, 3'd2},
        {7'b1101111, 3'd4, 1'b1, 3'd5}
    };

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [6:0] lines, input logic [2:0] m);
        rst_n = 1'b0;
        irq_n = lines;
        mask  = m;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic strobe_boundary;
        boundary = 1'b1;
        tick(1);
        boundary = 1'b0;
    endtask

    task automatic send_ack(input logic [2:0] lvl);
        ack_valid = 1'b1;
        ack_level = lvl;
        tick(1);
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9 reset state
        rst_n = 1'b0;
        tick(2);
        check("R9 pend at reset", pend, 0);
        check("R9 level at reset", pend_level, 0);

        // vector walk: R2 R3 R7 with R4 gating
        for (int i = 0; i < 14; i++) begin
            do_reset(7'h7F, VEC[i][6:4]);
            irq_n = VEC[i][13:7];
            tick(4);
            check("R4 no pend before boundary", pend, 0);
            strobe_boundary();
            check("R2/R3 pend", pend, int'(VEC[i][3]));
            check("R2/R3 level", pend_level, int'(VEC[i][2:0]));
        end

        // R1 one-sample glitch ignored, two samples accepted
        do_reset(7'h7F, 3'd0);
        irq_n = 7'b1111011;
        tick(1);
        irq_n = 7'h7F;
        tick(3);
        strobe_boundary();
        check("R1 glitch ignored", pend, 0);
        irq_n = 7'b1111011;
        tick(3);
        strobe_boundary();
        check("R1 held line pend", pend, 1);
        check("R1 held line level", pend_level, 3);

        // R5 preemption, R6 wrong then right ack, R10 withdraw
        do_reset(7'h7F, 3'd0);
        irq_n = 7'b1111101;
        tick(3);
        strobe_boundary();
        check("R5 low level presented", pend_level, 2);
        irq_n = 7'b1101101;
        tick(3);
        check("R5 preempt pend", pend, 1);
        check("R5 preempt level", pend_level, 5);
        send_ack(3'd2);
        check("R6 wrong ack ignored", pend, 1);
        check("R6 wrong ack level", pend_level, 5);
        send_ack(3'd5);
        check("R6 matching ack clears", pend, 0);
        irq_n = 7'b1111101;
        tick(3);
        strobe_boundary();
        check("R10 re-grant level", pend_level, 2);
        irq_n = 7'h7F;
        tick(3);
        check("R10 withdraw pend", pend, 0);
        check("R10 withdraw level", pend_level, 0);

        // R9 line low at reset, R7 no repeat, R8 re-trigger on mask write
        do_reset(7'b0111111, 3'd7);
        tick(3);
        strobe_boundary();
        check("R9 low-at-reset gives request", pend, 1);
        check("R7 level 7 at mask 7", pend_level, 7);
        send_ack(3'd7);
        check("R7 ack clears", pend, 0);
        tick(2);
        strobe_boundary();
        check("R7 held line not repeated", pend, 0);
        mask    = 3'd7;
        mask_wr = 1'b1;
        tick(1);
        mask_wr = 1'b0;
        check("R4 mask write alone no pend", pend, 0);
        strobe_boundary();
        check("R8 re-trigger pend", pend, 1);
        check("R8 re-trigger level", pend_level, 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule